// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core that uses overlapping register windows and several banks of global registers. Each access presents an architectural register index; the block turns it into a physical storage slot using the current window pointer and the current global level, then reads or writes that slot. Two read ports are combinational. The single write port commits on the rising clock edge.

The architectural index space has five legal regions. Indices 0-7 are globals and select a bank of eight chosen by the global level. Indices 8 up to the architectural count are windowed: each window step moves sixteen physical slots and the rotation wraps around. A small set of micro-op scratch registers sits directly above the architectural range. Two alias ranges follow it. One reaches the window below the current one, the other the window above it. In both alias ranges the globals still use the current bank. Any index beyond the last alias range is illegal. An illegal read returns zero and raises a flag. An illegal write is dropped and raises a flag. Window overflow or underflow traps and the save/restore sequencing belong to the surrounding pipeline.

Top module: `windowed_int_rf`

## Requirements
- R1: With the defaults (8 windows, global levels 0-3, 32 architectural and 8 micro-op indices), an index g in 0..7 selects physical slot g + 8*GL. Each global level owns a separate bank of eight.
- R2: An index r in 8..31 selects physical slot 32 + ((r - 8) + 16*(8 - CWP)) mod 128. Changing CWP by one therefore shifts the window by sixteen slots.
- R3: Window arithmetic wraps. At CWP = 7 the next window is window 0, and at CWP = 0 the previous window is window 7.
- R4: Indices 32..39 select micro-op slots 160..167 (index - 32 + 160). The result does not depend on CWP or GL.
- R5: Indices 40..71 alias index (i - 40) taken in window CWP-1. Globals in this range use the current GL bank.
- R6: Indices 72..103 alias index (i - 72) taken in window CWP+1. Globals in this range use the current GL bank. A value written through this range is read back at the base index after CWP is incremented.
- R7: An index of 104 or more is illegal. The read port raises its bad flag and returns zero.
- R8: A write with an illegal index raises wr_bad_o in that cycle and changes no storage.
- R9: A write takes effect at the rising clock edge. With the default of no bypass, a read of the same slot in the same cycle returns the old value.
- R10: A synchronous active-low reset clears every physical slot to zero.
- R11: The two read ports are independent. Equal indices give equal data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cwp_i | input | 3 | Current window pointer |
| gl_i | input | 2 | Current global level |
| rd0_idx_i | input | 7 | Read port 0 architectural index |
| rd0_data_o | output | 32 | Read port 0 data |
| rd0_bad_o | output | 1 | Read port 0 index illegal |
| rd1_idx_i | input | 7 | Read port 1 architectural index |
| rd1_data_o | output | 32 | Read port 1 data |
| rd1_bad_o | output | 1 | Read port 1 index illegal |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 7 | Write architectural index |
| wr_data_i | input | 32 | Write data |
| wr_bad_o | output | 1 | Write requested with illegal index |

## Verification
The assertions check several properties on every cycle. Storage seen through a port holds still when no legal write occurs, and an illegal write leaves it untouched. A legal write is visible one cycle later at the same index. Illegal reads return zero, both ports agree on equal indices, and reset leaves zeros. The index mapping itself can be shown only by the bench scenarios. The bench sweeps every window pointer, global level and index against an arithmetic model of the flattening. It also drives the specific alias, wraparound and read-during-write sequences.

// File: rtl/rf_win_pkg.sv
// Package: shared types for the windowed integer register file.
// Assumes nothing; holds only the index-region encoding.
package rf_win_pkg;

    // Region an architectural index falls into after decoding
    typedef enum logic [2:0] {
        REG_GLOBAL = 3'd0,
        REG_WINDOW = 3'd1,
        REG_MICRO  = 3'd2,
        REG_PREV   = 3'd3,
        REG_NEXT   = 3'd4,
        REG_BAD    = 3'd5
    } idx_region_e;

endpackage

// File: rtl/rf_index_map.sv
// Module: rf_index_map
// Flattens one architectural register index into a physical slot number.
// Inputs are the window pointer and the global level.
// Assumes gl_i <= MAX_GL and cwp_i < NWIN; all arithmetic stays non-negative.
module rf_index_map
    import rf_win_pkg::*;
#(
    parameter int NWIN    = 8,
    parameter int MAX_GL  = 3,
    parameter int N_ARCH  = 32,
    parameter int N_MICRO = 8,
    parameter int IDX_W   = 7,
    parameter int CWP_W   = 3,
    parameter int GL_W    = 2,
    parameter int PHYS_W  = 8
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [CWP_W-1:0]  cwp_i,
    input  logic [GL_W-1:0]   gl_i,
    output logic [PHYS_W-1:0] phys_o,
    output logic              bad_o
);

    localparam int N_GLOB    = (MAX_GL + 1) * 8;
    localparam int WIN_SPAN  = NWIN * 16;
    localparam int PREV_BASE = N_ARCH + N_MICRO;
    localparam int NEXT_BASE = 2 * N_ARCH + N_MICRO;
    localparam int LIMIT     = 3 * N_ARCH + N_MICRO;
    localparam int MICRO_OFS = N_GLOB + WIN_SPAN;

    idx_region_e region;
    logic [31:0] idx32;
    logic [31:0] cwp32;
    logic [31:0] gl32;
    logic [31:0] local_idx;
    logic [31:0] win_add;
    logic [31:0] win_sel;
    logic [31:0] phys32;

    assign idx32 = 32'(idx_i);
    assign cwp32 = 32'(cwp_i);
    assign gl32  = 32'(gl_i);

    // Classify the index and strip the alias offset
    always_comb begin
        region    = REG_BAD;
        local_idx = '0;
        win_add   = '0;
        if (idx32 < 32'd8) begin
            region    = REG_GLOBAL;
            local_idx = idx32;
        end else if (idx32 < 32'(N_ARCH)) begin
            region    = REG_WINDOW;
            local_idx = idx32;
        end else if (idx32 < 32'(PREV_BASE)) begin
            region    = REG_MICRO;
            local_idx = idx32 - 32'(N_ARCH);
        end else if (idx32 < 32'(NEXT_BASE)) begin
            region    = REG_PREV;
            local_idx = idx32 - 32'(PREV_BASE);
            win_add   = 32'(NWIN - 1);
        end else if (idx32 < 32'(LIMIT)) begin
            region    = REG_NEXT;
            local_idx = idx32 - 32'(NEXT_BASE);
            win_add   = 32'd1;
        end
    end

    // Window actually addressed, reduced modulo the window count
    assign win_sel = (cwp32 + win_add) % 32'(NWIN);

    // Compute the physical slot for the decoded region
    always_comb begin
        phys32 = '0;
        if (region == REG_MICRO) begin
            phys32 = 32'(MICRO_OFS) + local_idx;
        end else if (region != REG_BAD && local_idx < 32'd8) begin
            phys32 = local_idx + gl32 * 32'd8;
        end else if (region != REG_BAD) begin
            phys32 = 32'(N_GLOB)
                   + ((local_idx - 32'd8 + (32'(NWIN) - win_sel) * 32'd16)
                      % 32'(WIN_SPAN));
        end
    end

    assign phys_o = PHYS_W'(phys32);
    assign bad_o  = (region == REG_BAD);

endmodule

// File: rtl/rf_phys_store.sv
// Module: rf_phys_store
// Flat physical register array with one synchronous write port and
// N_RD combinational read ports. The optional write-to-read bypass is
// chosen by parameter. Assumes every write address is below DEPTH.
module rf_phys_store #(
    parameter int DEPTH  = 168,
    parameter int XLEN   = 32,
    parameter int ADDR_W = 8,
    parameter int N_RD   = 2,
    parameter bit BYPASS = 1'b0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [ADDR_W-1:0]              waddr_i,
    input  logic [XLEN-1:0]                wdata_i,
    input  logic [N_RD-1:0][ADDR_W-1:0]    raddr_i,
    output logic [N_RD-1:0][XLEN-1:0]      rdata_o
);

    logic [XLEN-1:0] mem [DEPTH];

    // Clear all slots on reset, otherwise commit the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // One read path per port, with or without bypass
    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        if (BYPASS) begin : g_byp
            assign rdata_o[p] = (we_i && waddr_i == raddr_i[p])
                              ? wdata_i : mem[raddr_i[p]];
        end else begin : g_nobyp
            assign rdata_o[p] = mem[raddr_i[p]];
        end
    end

endmodule

// File: rtl/windowed_int_rf.sv
// Module: windowed_int_rf
// Integer register file with overlapping windows, banked globals,
// micro-op scratch registers and previous/next window alias ranges.
// Every port index goes through its own flattening unit. Illegal reads
// return zero and illegal writes are dropped. Assumes GL <= MAX_GL.
module windowed_int_rf #(
    parameter int NWIN    = 8,
    parameter int MAX_GL  = 3,
    parameter int N_ARCH  = 32,
    parameter int N_MICRO = 8,
    parameter int XLEN    = 32,
    parameter bit BYPASS  = 1'b0,
    localparam int N_GLOB = (MAX_GL + 1) * 8,
    localparam int DEPTH  = N_GLOB + NWIN * 16 + N_MICRO,
    localparam int IDX_W  = $clog2(3 * N_ARCH + N_MICRO),
    localparam int CWP_W  = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int GL_W   = (MAX_GL > 0) ? $clog2(MAX_GL + 1) : 1,
    localparam int PHYS_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CWP_W-1:0] cwp_i,
    input  logic [GL_W-1:0]  gl_i,
    input  logic [IDX_W-1:0] rd0_idx_i,
    output logic [XLEN-1:0]  rd0_data_o,
    output logic             rd0_bad_o,
    input  logic [IDX_W-1:0] rd1_idx_i,
    output logic [XLEN-1:0]  rd1_data_o,
    output logic             rd1_bad_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [XLEN-1:0]  wr_data_i,
    output logic             wr_bad_o
);

    localparam int N_RD = 2;

    logic [N_RD-1:0][IDX_W-1:0]  rd_idx;
    logic [N_RD-1:0][PHYS_W-1:0] rd_phys;
    logic [N_RD-1:0]             rd_bad;
    logic [N_RD-1:0][XLEN-1:0]   rd_raw;
    logic [PHYS_W-1:0]           wr_phys;
    logic                        wr_idx_bad;

    assign rd_idx[0] = rd0_idx_i;
    assign rd_idx[1] = rd1_idx_i;

    // One flattening unit per read port
    for (genvar p = 0; p < N_RD; p++) begin : g_rmap
        rf_index_map #(
            .NWIN(NWIN), .MAX_GL(MAX_GL), .N_ARCH(N_ARCH), .N_MICRO(N_MICRO),
            .IDX_W(IDX_W), .CWP_W(CWP_W), .GL_W(GL_W), .PHYS_W(PHYS_W)
        ) u_map (
            .idx_i (rd_idx[p]),
            .cwp_i (cwp_i),
            .gl_i  (gl_i),
            .phys_o(rd_phys[p]),
            .bad_o (rd_bad[p])
        );
    end

    // Flattening unit for the write port
    rf_index_map #(
        .NWIN(NWIN), .MAX_GL(MAX_GL), .N_ARCH(N_ARCH), .N_MICRO(N_MICRO),
        .IDX_W(IDX_W), .CWP_W(CWP_W), .GL_W(GL_W), .PHYS_W(PHYS_W)
    ) u_wmap (
        .idx_i (wr_idx_i),
        .cwp_i (cwp_i),
        .gl_i  (gl_i),
        .phys_o(wr_phys),
        .bad_o (wr_idx_bad)
    );

    // Physical storage
    rf_phys_store #(
        .DEPTH(DEPTH), .XLEN(XLEN), .ADDR_W(PHYS_W),
        .N_RD(N_RD), .BYPASS(BYPASS)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (wr_en_i && !wr_idx_bad),
        .waddr_i(wr_phys),
        .wdata_i(wr_data_i),
        .raddr_i(rd_phys),
        .rdata_o(rd_raw)
    );

    // Mask data of illegal reads and expose the flags
    assign rd0_data_o = rd_bad[0] ? '0 : rd_raw[0];
    assign rd1_data_o = rd_bad[1] ? '0 : rd_raw[1];
    assign rd0_bad_o  = rd_bad[0];
    assign rd1_bad_o  = rd_bad[1];
    assign wr_bad_o   = wr_en_i && wr_idx_bad;

endmodule

// File: rtl/rf_win_checker.sv
// Module: rf_win_checker
// Port-level temporal checks for windowed_int_rf, attached by bind.
// Assumes the default no-bypass read behaviour for the hold checks.
module rf_win_checker #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 7,
    parameter int CWP_W = 3,
    parameter int GL_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CWP_W-1:0] cwp_i,
    input logic [GL_W-1:0]  gl_i,
    input logic [IDX_W-1:0] rd0_idx_i,
    input logic [XLEN-1:0]  rd0_data_o,
    input logic             rd0_bad_o,
    input logic [IDX_W-1:0] rd1_idx_i,
    input logic [XLEN-1:0]  rd1_data_o,
    input logic             rd1_bad_o,
    input logic             wr_en_i,
    input logic [IDX_W-1:0] wr_idx_i,
    input logic [XLEN-1:0]  wr_data_i,
    input logic             wr_bad_o
);

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_bad_o |-> rd0_data_o == '0) and (rd1_bad_o |-> rd1_data_o == '0)); // R7

    AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_bad_o) ##1 ($stable(rd0_idx_i) && $stable(cwp_i)
        && $stable(gl_i) && !wr_en_i) |-> $stable(rd0_data_o)); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i) ##1 ($stable(rd0_idx_i) && $stable(cwp_i)
        && $stable(gl_i) && !wr_en_i) |-> $stable(rd0_data_o)); // R9

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_bad_o) ##1 (rd0_idx_i == $past(wr_idx_i)
        && $stable(cwp_i) && $stable(gl_i) && !wr_en_i)
        |-> rd0_data_o == $past(wr_data_i)); // R9

    AST_RESET_ZERO: assert property (@(posedge clk)
        (!rst_n) |=> (wr_en_i || (rd0_data_o == '0 && rd1_data_o == '0))); // R10

    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_idx_i == rd1_idx_i) |-> (rd0_data_o == rd1_data_o
        && rd0_bad_o == rd1_bad_o)); // R11

endmodule

bind windowed_int_rf rf_win_checker #(
    .XLEN(XLEN), .IDX_W(IDX_W), .CWP_W(CWP_W), .GL_W(GL_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cwp_i(cwp_i), .gl_i(gl_i),
    .rd0_idx_i(rd0_idx_i), .rd0_data_o(rd0_data_o), .rd0_bad_o(rd0_bad_o),
    .rd1_idx_i(rd1_idx_i), .rd1_data_o(rd1_data_o), .rd1_bad_o(rd1_bad_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .wr_bad_o(wr_bad_o)
);

// File: tb/test_windowed_int_rf.sv
// Bench: sweeps every window pointer, global level and index against an
// arithmetic model of the flattening, then drives directed corner cases.
module test_windowed_int_rf;

    localparam int NW = 8, MG = 3, NA = 32, NM = 8;
    localparam int NG = (MG + 1) * 8, SPAN = NW * 16;
    localparam int PB = NA + NM, NB = 2 * NA + NM, LIM = 3 * NA + NM;
    localparam int DEPTH = NG + SPAN + NM;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cwp = '0;
    logic [1:0]  gl = '0;
    logic [6:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
    logic [31:0] rd0_data, rd1_data, wr_data = '0;
    logic        rd0_bad, rd1_bad, wr_bad, wr_en = 1'b0;

    logic [31:0] model [DEPTH];
    int errors = 0, checks = 0, seq = 1;
    bit done = 1'b0;

    always #10 clk = ~clk;

    windowed_int_rf #(.NWIN(NW), .MAX_GL(MG), .N_ARCH(NA), .N_MICRO(NM),
                      .XLEN(32), .BYPASS(1'b0)) i_windowed_int_rf (
        .clk(clk), .rst_n(rst_n), .cwp_i(cwp), .gl_i(gl),
        .rd0_idx_i(rd0_idx), .rd0_data_o(rd0_data), .rd0_bad_o(rd0_bad),
        .rd1_idx_i(rd1_idx), .rd1_data_o(rd1_data), .rd1_bad_o(rd1_bad),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .wr_bad_o(wr_bad)
    );

    // Reference flattening, -1 for an illegal index
    function automatic int ref_phys(int r, int c, int g);
        if (r < 8)  return r + g * 8;
        if (r < NA) return NG + ((r - 8 - c * 16 + SPAN) % SPAN);
        if (r < PB) return r - NA + NG + SPAN;
        if (r < NB) begin
            r -= PB;
            if (r < 8) return r + g * 8;
            return NG + ((r - 8 - (c - 1) * 16 + SPAN) % SPAN);
        end
        if (r < LIM) begin
            r -= NB;
            if (r < 8) return r + g * 8;
            return NG + ((r - 8 - (c + 1) * 16 + SPAN) % SPAN);
        end
        return -1;
    endfunction

    function automatic string tag_of(int r);
        if (r < 8)   return "R1";
        if (r < NA)  return "R2";
        if (r < PB)  return "R4";
        if (r < NB)  return "R5";
        if (r < LIM) return "R6";
        return "R7";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_data(int r);
        int ph = ref_phys(r, int'(cwp), int'(gl));
        return (ph < 0) ? 32'h0 : model[ph];
    endfunction

    // Read every index on both ports at the current CWP/GL and compare
    task automatic check_all(string phase);
        for (int i = 0; i < 128; i++) begin
            int j = (i + 37) % 128;
            rd0_idx = 7'(i);
            rd1_idx = 7'(j);
            #1;
            check($sformatf("%s %s idx=%0d cwp=%0d gl=%0d", phase, tag_of(i), i, cwp, gl),
                  rd0_data, exp_data(i));
            check($sformatf("%s %s bad idx=%0d", phase, tag_of(i), i),
                  32'(rd0_bad), 32'(ref_phys(i, 0, 0) < 0));
            check($sformatf("%s R11 %s port1 idx=%0d", phase, tag_of(j), j),
                  rd1_data, exp_data(j));
        end
    endtask

    // One write cycle; called at a negedge, returns at the next negedge
    task automatic write_one(int idx, logic [31:0] d);
        int ph = ref_phys(idx, int'(cwp), int'(gl));
        wr_en = 1'b1;
        wr_idx = 7'(idx);
        wr_data = d;
        #1;
        check($sformatf("R8 wr_bad idx=%0d", idx), 32'(wr_bad), 32'(ph < 0));
        @(negedge clk);
        wr_en = 1'b0;
        if (ph >= 0) model[ph] = d;
    endtask

    function automatic logic [31:0] next_data();
        seq++;
        return (32'(seq) * 32'h9E3779B1) ^ 32'h5A5A_0000;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            report();
        end
    end

    initial begin
        logic [31:0] d, old;
        do_reset();

        // R10: everything reads zero after reset
        for (int c = 0; c < NW; c += 3) begin
            cwp = 3'(c);
            gl = 2'(c % 4);
            check_all("R10 reset");
        end

        // Full sweep: write every index at every CWP/GL, read all back
        for (int c = 0; c < NW; c++) begin
            for (int g = 0; g <= MG; g++) begin
                cwp = 3'(c);
                gl = 2'(g);
                for (int i = 0; i < 128; i++) write_one(i, next_data());
                check_all("sweep");
            end
        end
        // Cross-check all combinations after the sweep (R1, R2 independence)
        for (int c = 0; c < NW; c++) begin
            for (int g = 0; g <= MG; g++) begin
                cwp = 3'(c);
                gl = 2'(g);
                check_all("cross");
            end
        end

        // R9: read during write returns old value, new after the edge
        cwp = 3'd2; gl = 2'd1;
        rd0_idx = 7'd9;
        old = exp_data(9);
        d = next_data();
        wr_en = 1'b1; wr_idx = 7'd9; wr_data = d;
        #1;
        check("R9 same-cycle read old", rd0_data, old);
        @(negedge clk);
        wr_en = 1'b0;
        model[ref_phys(9, 2, 1)] = d;
        #1;
        check("R9 read after edge", rd0_data, d);

        // R6: write via next alias, increment CWP, read base index
        @(negedge clk);
        cwp = 3'd3; gl = 2'd1;
        d = next_data();
        write_one(NB + 10, d);
        cwp = 3'd4;
        rd0_idx = 7'd10; #1;
        check("R6 next alias seen at CWP+1", rd0_data, d);

        // R3: wrap from window 7 to window 0 through the next alias
        cwp = 3'd7;
        d = next_data();
        write_one(NB + 20, d);
        cwp = 3'd0;
        rd0_idx = 7'd20; #1;
        check("R3 next alias wraps to window 0", rd0_data, d);

        // R3/R5: previous alias at CWP 0 reaches window 7
        d = next_data();
        write_one(PB + 12, d);
        cwp = 3'd7;
        rd0_idx = 7'd12; #1;
        check("R3 R5 prev alias wraps to window 7", rd0_data, d);

        // R5/R6: alias globals use the current GL bank
        gl = 2'd2;
        d = next_data();
        write_one(NB + 3, d);
        rd0_idx = 7'd3; rd1_idx = 7'(PB + 3); #1;
        check("R6 alias global in current bank", rd0_data, d);
        check("R5 prev alias global in current bank", rd1_data, d);
        gl = 2'd1; #1;
        check("R1 other bank untouched", rd0_data == d ? 32'd1 : 32'd0, 32'd0);

        // R4: micro register independent of CWP and GL
        cwp = 3'd2;
        d = next_data();
        write_one(NA + 3, d);
        cwp = 3'd5; gl = 2'd3;
        rd0_idx = 7'(NA + 3); #1;
        check("R4 micro reg ignores CWP/GL", rd0_data, d);

        // R7: illegal reads give zero and a flag
        rd0_idx = 7'(LIM); rd1_idx = 7'd127; #1;
        check("R7 illegal read data", rd0_data, 32'h0);
        check("R7 illegal read flag", 32'(rd1_bad), 32'd1);

        // R8: illegal write leaves every legal slot unchanged
        @(negedge clk);
        write_one(LIM + 5, 32'hDEAD_BEEF);
        check_all("R8 after illegal write");

        // R10: mid-run reset clears storage
        do_reset();
        cwp = 3'd6; gl = 2'd3;
        check_all("R10 mid-run reset");

        done = 1'b1;
        report();
    end

endmodule